// File: doc/BRIEF.md
# Broadcast Translation-Entry Invalidate Matcher

This block applies a translation invalidate request, broadcast by another agent, to every entry of a local translation table at once. The request carries three things: a virtual page number, an address-space identifier, and three rule flags. The flags choose whether entries are selected by address alone, by address together with identifier, or by identifier alone. A request with no flag set selects every entry. The table supplies each entry's page number, page-size mask, identifier and global bit. The block returns one write-enable per entry. The table uses that enable to set the entry's hardware-invalidate bit and leaves the rest of the entry untouched.

A one-cycle start strobe launches a request. All entries are compared in parallel in the same cycle. On the following cycle the block drives the per-entry invalidate enables together with a one-cycle completion pulse. Carrying the request between agents and acknowledging it are handled elsewhere.

Top module: `ginv_sweep`

## Requirements
- R1: An entry's address matches when its page number equals the request page number in every bit position where the entry's own page mask bit is 0. Bits where the mask is 1 are ignored.
- R2: An entry's identifier matches when its identifier equals the request identifier in all bits.
- R3: With flag `req_by_addr` set, every entry that matches by address is selected, whatever its identifier and global bit.
- R4: With flag `req_by_addr_id` set, an entry that matches by address is selected when it is global or when it matches by identifier.
- R5: With flag `req_by_id` set, an entry is selected only when it matches by identifier and its global bit is 0.
- R6: When more than one flag is set, the selected set is the union of the sets each set flag would select.
- R7: When no flag is set, every entry is selected.
- R8: A start strobe sampled at a rising edge makes `done` high, and `inv_we` equal to the selected set (bit i for entry i), for exactly the following clock cycle. The entry and request inputs are taken at that same edge.
- R9: In every cycle not following a start, `done` is 0 and `inv_we` is all zeros.
- R10: While the synchronous active-high reset is applied, and in the cycle after it, `done` and `inv_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| req_vpn | input | VPN_W | Request virtual page number |
| req_id | input | ID_W | Request address-space identifier |
| req_by_addr | input | 1 | Rule flag: select by address |
| req_by_addr_id | input | 1 | Rule flag: select by address and identifier/global |
| req_by_id | input | 1 | Rule flag: select non-global entries by identifier |
| ent_vpn | input | ENTRIES*VPN_W | Entry page numbers, entry i at bits [i*VPN_W +: VPN_W] |
| ent_mask | input | ENTRIES*VPN_W | Entry page masks (1 = ignored bit), same packing |
| ent_id | input | ENTRIES*ID_W | Entry identifiers, entry i at bits [i*ID_W +: ID_W] |
| ent_global | input | ENTRIES | Entry global bits |
| inv_we | output | ENTRIES | Per-entry invalidate write enables |
| done | output | 1 | Completion pulse, one cycle after start |

## Verification
Some properties are checked by assertions on every cycle. One is the pulse timing of `done`. Another is that enables never appear without `done`. A third is that an identifier-only request never selects a global entry. The last is that a request with no flag set selects the whole table. Whether each entry is selected correctly cannot be seen by those checks, so it is left to the bench. That covers the masked address comparison, the identifier comparison, the per-rule treatment of the global bit, and the union of several flags. The bench sweeps request page numbers, identifiers and all eight flag combinations against tables of varied masks, identifiers and global bits.

// File: rtl/ginv_pkg.sv
package ginv_pkg;

    typedef struct packed {
        logic by_addr;
        logic by_addr_id;
        logic by_id;
    } ginv_rule_t;

    typedef struct packed {
        logic addr_hit;
        logic id_hit;
        logic global;
    } ginv_probe_t;

    function automatic logic ginv_any_rule(input ginv_rule_t r);
        return r.by_addr | r.by_addr_id | r.by_id;
    endfunction

    function automatic logic ginv_select(input ginv_rule_t r, input ginv_probe_t p);
        logic sel;
        sel = 1'b0;
        if (!ginv_any_rule(r)) begin
            sel = 1'b1;
        end else begin
            if (r.by_addr && p.addr_hit)
                sel = 1'b1;
            if (r.by_addr_id && p.addr_hit && (p.global || p.id_hit))
                sel = 1'b1;
            if (r.by_id && p.id_hit && !p.global)
                sel = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/ginv_entry_cmp.sv
module ginv_entry_cmp #(
    parameter int VPN_W = 20,
    parameter int ID_W  = 16
) (
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [VPN_W-1:0] e_mask,
    input  logic [ID_W-1:0]  e_id,
    input  logic [VPN_W-1:0] r_vpn,
    input  logic [ID_W-1:0]  r_id,
    output logic             addr_hit,
    output logic             id_hit
);
    logic [VPN_W-1:0] keep;
    logic [VPN_W-1:0] diff;

    always_comb begin
        keep     = ~e_mask;
        diff     = (e_vpn & keep) ^ (r_vpn & keep);
        addr_hit = (diff == '0);
        id_hit   = (e_id == r_id);
    end
endmodule

// File: rtl/ginv_rule_eval.sv
module ginv_rule_eval
    import ginv_pkg::*;
(
    input  ginv_rule_t  rule,
    input  ginv_probe_t probe,
    output logic        sel
);
    always_comb begin
        sel = ginv_select(rule, probe);
    end

    always_comb begin
        if (rule == 3'b001 && probe.global)
            a_r5_id_rule_spares_global: assert (!sel);
    end
endmodule

// File: rtl/ginv_sweep.sv
module ginv_sweep
    import ginv_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ID_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [ID_W-1:0]          req_id,
    input  logic                     req_by_addr,
    input  logic                     req_by_addr_id,
    input  logic                     req_by_id,
    input  logic [ENTRIES*VPN_W-1:0] ent_vpn,
    input  logic [ENTRIES*VPN_W-1:0] ent_mask,
    input  logic [ENTRIES*ID_W-1:0]  ent_id,
    input  logic [ENTRIES-1:0]       ent_global,
    output logic [ENTRIES-1:0]       inv_we,
    output logic                     done
);
    localparam int VW = VPN_W * ENTRIES;

    ginv_rule_t         rule;
    logic [ENTRIES-1:0] sel_vec;
    logic [ENTRIES-1:0] inv_q;
    logic               done_q;

    assign rule = '{by_addr: req_by_addr, by_addr_id: req_by_addr_id, by_id: req_by_id};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic        a_hit;
        logic        i_hit;
        ginv_probe_t probe;

        ginv_entry_cmp #(.VPN_W(VPN_W), .ID_W(ID_W)) u_cmp (
            .e_vpn    (ent_vpn[i*VPN_W +: VPN_W]),
            .e_mask   (ent_mask[i*VPN_W +: VPN_W]),
            .e_id     (ent_id[i*ID_W +: ID_W]),
            .r_vpn    (req_vpn),
            .r_id     (req_id),
            .addr_hit (a_hit),
            .id_hit   (i_hit)
        );

        assign probe = '{addr_hit: a_hit, id_hit: i_hit, global: ent_global[i]};

        ginv_rule_eval u_rule (
            .rule  (rule),
            .probe (probe),
            .sel   (sel_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_q  <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            inv_q  <= sel_vec;
            done_q <= 1'b1;
        end else begin
            inv_q  <= '0;
            done_q <= 1'b0;
        end
    end

    assign inv_we = inv_q;
    assign done   = done_q;

    a_r8_done_follows_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r9_done_needs_start: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    a_r9_no_write_when_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> (inv_we == '0));

    a_r7_empty_rule_takes_all: assert property (@(posedge clk) disable iff (rst)
        (start && !ginv_any_rule(rule)) |=> (inv_we == {ENTRIES{1'b1}}));

    a_r5_id_rule_no_global: assert property (@(posedge clk) disable iff (rst)
        (start && rule == 3'b001) |=> ((inv_we & $past(ent_global)) == '0));

    a_r10_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!done && inv_we == '0));

    logic unused_vw;
    assign unused_vw = (VW == 0);
endmodule

// File: tb/ginv_sweep_test.sv
module ginv_sweep_test;
    localparam int N  = 4;
    localparam int VW = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic [VW-1:0]   req_vpn;
    logic [IW-1:0]   req_id;
    logic            f_a, f_ai, f_i;
    logic [N*VW-1:0] ent_vpn, ent_mask;
    logic [N*IW-1:0] ent_id;
    logic [N-1:0]    ent_global;
    logic [N-1:0]    inv_we;
    logic            done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ginv_sweep #(.ENTRIES(N), .VPN_W(VW), .ID_W(IW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .req_vpn(req_vpn), .req_id(req_id),
        .req_by_addr(f_a), .req_by_addr_id(f_ai), .req_by_id(f_i),
        .ent_vpn(ent_vpn), .ent_mask(ent_mask), .ent_id(ent_id),
        .ent_global(ent_global), .inv_we(inv_we), .done(done)
    );

    // Expected selection computed straight from R1..R7.
    function automatic logic [N-1:0] model(input logic [2:0] fl);
        logic [N-1:0] r;
        r = '0;
        for (int k = 0; k < N; k++) begin
            logic [VW-1:0] m;
            logic am, im, g;
            m  = ent_mask[k*VW +: VW];
            am = 1'b1;
            for (int b = 0; b < VW; b++)                      // R1
                if (!m[b] && ent_vpn[k*VW+b] != req_vpn[b]) am = 1'b0;
            im = (ent_id[k*IW +: IW] == req_id);              // R2
            g  = ent_global[k];
            if (fl == 3'b000) r[k] = 1'b1;                    // R7
            else r[k] = (fl[2] & am)                          // R3
                      | (fl[1] & am & (g | im))               // R4
                      | (fl[0] & im & !g);                    // R5, union R6
        end
        return r;
    endfunction

    function automatic string tag(input logic [2:0] fl);
        case (fl)
            3'b000: return "R7";
            3'b100: return "R3/R1";
            3'b010: return "R4/R2";
            3'b001: return "R5/R2";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input logic [N:0] act, input logic [N:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got done/inv=%b expected %b", rq, act, exp);
        end
    endtask

    task automatic load_table(input int s);
        for (int k = 0; k < N; k++) begin
            int sel;
            sel = (s + k) % 4;
            ent_vpn[k*VW +: VW]  = VW'((s * 5 + k * 3) & 15);
            ent_mask[k*VW +: VW] = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h3 : (sel == 2) ? 4'h1 : 4'hC;
            ent_id[k*IW +: IW]   = IW'((s + k) & 3);
            ent_global[k]        = ((s >> k) & 1) != 0;
        end
    endtask

    initial begin
        logic [N-1:0] exp;
        rst = 1'b1; start = 1'b0; req_vpn = '0; req_id = '0;
        f_a = 1'b0; f_ai = 1'b0; f_i = 1'b0;
        ent_vpn = '0; ent_mask = '0; ent_id = '0; ent_global = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && inv_we == '0, "R10", {done, inv_we}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && inv_we == '0, "R10", {done, inv_we}, '0);

        for (int s = 0; s < 8; s++) begin
            load_table(s);
            for (int fl = 0; fl < 8; fl++) begin
                for (int v = 0; v < 16; v++) begin
                    req_vpn = VW'(v);
                    req_id  = IW'((v + s) & 3);
                    {f_a, f_ai, f_i} = 3'(fl);
                    exp   = model(3'(fl));
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                    check(done == 1'b1 && inv_we == exp,
                          $sformatf("R8 %s", tag(3'(fl))), {done, inv_we}, {1'b1, exp});
                    // R9: idle cycle, inputs still present but no strobe.
                    @(negedge clk);
                    check(done == 1'b0 && inv_we == '0, "R9", {done, inv_we}, '0);
                end
            end
        end

        // R10: reset in the middle of a request suppresses it.
        start = 1'b1; rst = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b0;
        check(done == 1'b0 && inv_we == '0, "R10", {done, inv_we}, '0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule